// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block is the digital sequencer that steps a successive-approximation converter through a list of analog channels. Software enables channels with a bit mask. A trigger launches work. The trigger is either a rising edge on one selectable hardware line or a software start pulse. For each conversion the sequencer places a channel index on `ch_sel`, strobes `soc` for one cycle and waits for the converter's `conv_done` handshake. It then reports end-of-conversion, and also end-of-sequence when the converted channel is the highest enabled one.

Three operating styles exist. In the default style one trigger runs the whole list. In discontinuous style each trigger converts only the next channel, and the position is remembered between triggers. In continuous style the list restarts by itself after each end-of-sequence until the start flag is cleared. Discontinuous and continuous together is an illegal setting. It is flagged and blocks all triggers. A trigger that arrives while the sequencer is busy is dropped and recorded in a sticky overrun flag.

Top module: `adc_seq_ctrl`

## Requirements
- R1: With `discont_en`=0, one accepted trigger converts every channel whose `ch_mask` bit is 1, in ascending index order. Each conversion is announced by `soc` high for exactly one cycle, with `ch_sel` holding the channel index until `conv_done` is seen.
- R2: One cycle after `conv_done` is seen, `eoc` pulses for one cycle. `eos` pulses together with it only when the converted channel is the highest set bit of `ch_mask`.
- R3: With `discont_en`=1, each trigger converts exactly one channel: the next enabled channel above the last one converted. After the highest enabled channel, the next trigger wraps to the lowest enabled channel.
- R4: With `discont_en`=0, every new trigger restarts the list from the lowest enabled channel.
- R5: With `cont_en`=1 and `discont_en`=0, the list restarts automatically after end-of-sequence while `start_flag` is 1. Once `start_flag` is cleared, the conversion in progress completes and no further `soc` occurs.
- R6: `cfg_err` is 1 exactly when `discont_en` and `cont_en` are both 1. While it is set, no trigger starts a conversion and `sw_start_set` does not set `start_flag`.
- R7: A `trig_sel_wr` pulse copies `trig_sel` into `trig_sel_q` only while `start_flag` is 0. Writes made while it is 1 leave `trig_sel_q` unchanged.
- R8: `sw_start_set` sets `start_flag` and is itself a trigger. `sw_start_clr` clears `start_flag`.
- R9: A hardware trigger is a 0-to-1 transition of `hw_trig[trig_sel_q]`, after a two-stage synchronizer, seen while `start_flag` is 1. Unselected lines, edges while `start_flag` is 0, and a held high level cause no further conversion.
- R10: A trigger arriving while `busy` is 1 starts nothing and sets `ovr_flag`, which stays 1 until reset.
- R11: With `ch_mask` all zero, a trigger causes no `soc`.
- R12: After reset, `soc`, `eoc`, `eos`, `busy`, `start_flag`, `ovr_flag` and `trig_sel_q` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_mask | input | NUM_CH | Channel enable mask, bit i enables channel i |
| discont_en | input | 1 | One channel per trigger |
| cont_en | input | 1 | Automatic restart after end-of-sequence |
| trig_sel | input | SEL_W | Hardware trigger line to select |
| trig_sel_wr | input | 1 | Write strobe for `trig_sel` |
| hw_trig | input | NUM_HW_TRIG | Asynchronous hardware trigger lines |
| sw_start_set | input | 1 | Software start pulse (sets start flag, triggers) |
| sw_start_clr | input | 1 | Software stop pulse (clears start flag) |
| conv_done | input | 1 | Converter finished the current conversion |
| ch_sel | output | CH_W | Channel index presented to the converter |
| soc | output | 1 | Start-of-conversion strobe |
| eoc | output | 1 | End-of-conversion event |
| eos | output | 1 | End-of-sequence event |
| busy | output | 1 | A conversion is launched or in progress |
| start_flag | output | 1 | Sequencer armed |
| trig_sel_q | output | SEL_W | Active hardware trigger selection |
| cfg_err | output | 1 | Illegal mode combination |
| ovr_flag | output | 1 | Sticky trigger overrun |

## Verification
A corrupted discontinuous position pointer shows up at the very next trigger as a wrong `ch_sel` at `soc`, or as `eos` on a channel that is not the highest. The error is visible within one conversion. A wrong chaining decision shows within one conversion time as a missing or extra `soc`, or an `eos` count that disagrees with the mask's population. Faults in the trigger path (selection lock, edge detect, overrun) show up within a few cycles of the stimulus as a conversion that should not occur, a missing one, or an `ovr_flag` that disagrees with the bench's expectation. The bench sweeps every mask of a four-channel instance in both list styles, so each ordering and wrap position is compared.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_SOC  = 2'd1,
    SQ_WAIT = 2'd2
  } sq_state_t;
endpackage

// File: rtl/adc_trig_front.sv
module adc_trig_front #(
  parameter int NUM_HW_TRIG = 4,
  parameter int SEL_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_HW_TRIG-1:0] hw_trig,
  input  logic [SEL_W-1:0]       sel,
  output logic                   rise
);
  logic [NUM_HW_TRIG-1:0] stage1, stage2;
  logic lvl, lvl_d;

  // one two-flop synchronizer per hardware line
  for (genvar g = 0; g < NUM_HW_TRIG; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1[g] <= 1'b0;
        stage2[g] <= 1'b0;
      end else begin
        stage1[g] <= hw_trig[g];
        stage2[g] <= stage1[g];
      end
    end
  end

  always_comb begin
    lvl = 1'b0;
    for (int i = 0; i < NUM_HW_TRIG; i++)
      if (int'(sel) == i) lvl = stage2[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= 1'b0;
    else        lvl_d <= lvl;
  end

  assign rise = lvl & ~lvl_d;
endmodule

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
  parameter int NUM_CH = 16,
  parameter int CH_W = 4
) (
  input  logic [NUM_CH-1:0] mask,
  input  logic [CH_W-1:0]   base_idx,
  input  logic              base_valid,
  output logic              any,
  output logic [CH_W-1:0]   idx,
  output logic              last
);
  // lowest enabled channel at or above 'from'; MSB of result = found
  function automatic logic [CH_W:0] lowest_from(input logic [NUM_CH-1:0] m, input int from);
    logic [CH_W:0] r;
    r = '0;
    for (int i = NUM_CH - 1; i >= 0; i--)
      if (m[i] && i >= from) r = {1'b1, CH_W'(i)};
    return r;
  endfunction

  logic [CH_W:0] above, wrap, beyond;
  int start;

  always_comb begin
    start  = base_valid ? int'(base_idx) + 1 : 0;
    above  = lowest_from(mask, start);
    wrap   = lowest_from(mask, 0);
    idx    = above[CH_W] ? above[CH_W-1:0] : wrap[CH_W-1:0];
    beyond = lowest_from(mask, int'(idx) + 1);
    any    = |mask;
    last   = ~beyond[CH_W];
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int NUM_HW_TRIG = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int SEL_W = (NUM_HW_TRIG > 1) ? $clog2(NUM_HW_TRIG) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_CH-1:0]      ch_mask,
  input  logic                   discont_en,
  input  logic                   cont_en,
  input  logic [SEL_W-1:0]       trig_sel,
  input  logic                   trig_sel_wr,
  input  logic [NUM_HW_TRIG-1:0] hw_trig,
  input  logic                   sw_start_set,
  input  logic                   sw_start_clr,
  input  logic                   conv_done,
  output logic [CH_W-1:0]        ch_sel,
  output logic                   soc,
  output logic                   eoc,
  output logic                   eos,
  output logic                   busy,
  output logic                   start_flag,
  output logic [SEL_W-1:0]       trig_sel_q,
  output logic                   cfg_err,
  output logic                   ovr_flag
);
  sq_state_t state;
  logic [CH_W-1:0] cur_ch, pos;
  logic cur_last, pos_valid;
  logic eoc_q, eos_q;

  // named internal events, observed by the checker
  logic hw_rise, trig_evt, trig_accept, trig_drop, conv_finish, chain_next;
  logic pick_any, pick_last, base_valid;
  logic [CH_W-1:0] pick_idx, base_idx;

  adc_trig_front #(.NUM_HW_TRIG(NUM_HW_TRIG), .SEL_W(SEL_W)) front_i (
    .clk(clk), .rst_n(rst_n), .hw_trig(hw_trig), .sel(trig_sel_q), .rise(hw_rise)
  );

  // idle: pick from remembered position (discontinuous) or from the start;
  // running: pick the successor of the current channel, or restart after the last
  assign base_idx   = (state == SQ_IDLE) ? pos : cur_ch;
  assign base_valid = (state == SQ_IDLE) ? (discont_en & pos_valid) : ~cur_last;

  adc_chan_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) pick_i (
    .mask(ch_mask), .base_idx(base_idx), .base_valid(base_valid),
    .any(pick_any), .idx(pick_idx), .last(pick_last)
  );

  assign cfg_err     = discont_en & cont_en;
  assign busy        = (state != SQ_IDLE);
  assign trig_evt    = ~cfg_err & (sw_start_set | (hw_rise & start_flag));
  assign trig_accept = trig_evt & ~busy & pick_any;
  assign trig_drop   = trig_evt & busy;
  assign conv_finish = (state == SQ_WAIT) & conv_done;
  assign chain_next  = conv_finish & start_flag & ~discont_en & (~cur_last | cont_en) & pick_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      cur_ch   <= '0;
      cur_last <= 1'b0;
      eoc_q    <= 1'b0;
      eos_q    <= 1'b0;
    end else begin
      eoc_q <= 1'b0;
      eos_q <= 1'b0;
      unique case (state)
        SQ_IDLE: if (trig_accept) begin
          state    <= SQ_SOC;
          cur_ch   <= pick_idx;
          cur_last <= pick_last;
        end
        SQ_SOC: state <= SQ_WAIT;
        SQ_WAIT: if (conv_done) begin
          eoc_q <= 1'b1;
          eos_q <= cur_last;
          if (chain_next) begin
            state    <= SQ_SOC;
            cur_ch   <= pick_idx;
            cur_last <= pick_last;
          end else begin
            state <= SQ_IDLE;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos       <= '0;
      pos_valid <= 1'b0;
    end else if (conv_finish) begin
      pos       <= cur_ch;
      pos_valid <= discont_en & ~cur_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_flag <= 1'b0;
      trig_sel_q <= '0;
      ovr_flag   <= 1'b0;
    end else begin
      if (sw_start_set && !cfg_err) start_flag <= 1'b1;
      else if (sw_start_clr)        start_flag <= 1'b0;
      if (trig_sel_wr && !start_flag) trig_sel_q <= trig_sel;
      if (trig_drop) ovr_flag <= 1'b1;
    end
  end

  assign soc    = (state == SQ_SOC);
  assign ch_sel = cur_ch;
  assign eoc    = eoc_q;
  assign eos    = eos_q;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int NUM_CH = 16,
  parameter int CH_W = 4,
  parameter int SEL_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] ch_mask,
  input logic [CH_W-1:0]   ch_sel,
  input logic              soc,
  input logic              eoc,
  input logic              eos,
  input logic              busy,
  input logic              conv_done,
  input logic              start_flag,
  input logic [SEL_W-1:0]  trig_sel_q,
  input logic              cfg_err,
  input logic              ovr_flag,
  input logic              trig_drop
);
  AST_SOC_PULSE: assert property (@(posedge clk) disable iff (!rst_n) soc |=> !soc); // R1
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (busy && !conv_done) |=> $stable(ch_sel)); // R1
  AST_EOS_PAIRED: assert property (@(posedge clk) disable iff (!rst_n) eos |-> eoc); // R2
  AST_EOC_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) eoc |-> ($past(conv_done) && $past(busy))); // R2
  AST_CFG_BLOCK: assert property (@(posedge clk) disable iff (!rst_n) (cfg_err && !busy) |=> !soc); // R6
  AST_TSEL_LOCK: assert property (@(posedge clk) disable iff (!rst_n) start_flag |=> $stable(trig_sel_q)); // R7
  AST_DROP_OVR: assert property (@(posedge clk) disable iff (!rst_n) trig_drop |=> ovr_flag); // R10
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) ovr_flag |=> ovr_flag); // R10
  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (ch_mask == '0 && !busy) |=> !soc); // R11
endmodule

bind adc_seq_ctrl adc_seq_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W), .SEL_W(SEL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ch_mask(ch_mask), .ch_sel(ch_sel), .soc(soc),
  .eoc(eoc), .eos(eos), .busy(busy), .conv_done(conv_done),
  .start_flag(start_flag), .trig_sel_q(trig_sel_q), .cfg_err(cfg_err),
  .ovr_flag(ovr_flag), .trig_drop(trig_drop)
);

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
  localparam int NCH = 4;
  localparam int NHW = 2;
  localparam int CW  = 2;
  localparam int SW  = 1;
  localparam int LAT = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [NCH-1:0] ch_mask = '0;
  logic discont_en = 1'b0, cont_en = 1'b0;
  logic [SW-1:0] trig_sel = '0;
  logic trig_sel_wr = 1'b0;
  logic [NHW-1:0] hw_trig = '0;
  logic sw_start_set = 1'b0, sw_start_clr = 1'b0;
  logic conv_done;
  logic [CW-1:0] ch_sel;
  logic soc, eoc, eos, busy, start_flag, cfg_err, ovr_flag;
  logic [SW-1:0] trig_sel_q;

  adc_seq_ctrl #(.NUM_CH(NCH), .NUM_HW_TRIG(NHW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ch_mask(ch_mask), .discont_en(discont_en),
    .cont_en(cont_en), .trig_sel(trig_sel), .trig_sel_wr(trig_sel_wr),
    .hw_trig(hw_trig), .sw_start_set(sw_start_set), .sw_start_clr(sw_start_clr),
    .conv_done(conv_done), .ch_sel(ch_sel), .soc(soc), .eoc(eoc), .eos(eos),
    .busy(busy), .start_flag(start_flag), .trig_sel_q(trig_sel_q),
    .cfg_err(cfg_err), .ovr_flag(ovr_flag)
  );

  // converter stand-in: conv_done one cycle, LAT cycles after soc
  int cnt;
  always @(posedge clk) begin
    if (!rst_n) begin
      cnt <= 0;
      conv_done <= 1'b0;
    end else begin
      conv_done <= 1'b0;
      if (soc) cnt <= LAT;
      else if (cnt > 0) begin
        cnt <= cnt - 1;
        if (cnt == 1) conv_done <= 1'b1;
      end
    end
  end

  int soc_log[$];
  int eos_log[$];
  int stray_eos = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (soc) soc_log.push_back(int'(ch_sel));
      if (eoc) eos_log.push_back(int'(eos));
      if (eos && !eoc) stray_eos++;
    end
  end

  int n_cmp = 0, n_bad = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int popcnt(input int m);
    int c = 0;
    for (int i = 0; i < NCH; i++) if (m[i]) c++;
    return c;
  endfunction

  function automatic int kth_bit(input int m, input int k);
    int c = 0;
    for (int i = 0; i < NCH; i++)
      if (m[i]) begin
        if (c == k) return i;
        c++;
      end
    return -1;
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(posedge clk); #1 rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic pulse_set();
    sw_start_set = 1'b1; step(1); sw_start_set = 1'b0;
  endtask

  task automatic pulse_clr();
    sw_start_clr = 1'b1; step(1); sw_start_clr = 1'b0;
  endtask

  task automatic write_sel(input int v);
    trig_sel = SW'(v); trig_sel_wr = 1'b1; step(1); trig_sel_wr = 1'b0; step(1);
  endtask

  task automatic clear_logs();
    soc_log.delete();
    eos_log.delete();
  endtask

  // expected: nconv conversions cycling through the mask, eos on its highest bit
  task automatic check_seq(input string req, input int m, input int nconv);
    int n = popcnt(m);
    chk(req, "soc count", soc_log.size(), nconv);
    chk(req, "eoc count", eos_log.size(), nconv);
    for (int k = 0; k < nconv && k < soc_log.size() && k < eos_log.size(); k++) begin
      chk(req, $sformatf("mask %0d conv %0d channel", m, k), soc_log[k], kth_bit(m, k % n));
      chk("R2", $sformatf("mask %0d conv %0d eos", m, k), eos_log[k], ((k % n) == n - 1) ? 1 : 0);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    do_reset();
    // R12 reset state
    chk("R12", "soc", soc, 0);
    chk("R12", "eoc", eoc, 0);
    chk("R12", "eos", eos, 0);
    chk("R12", "busy", busy, 0);
    chk("R12", "start_flag", start_flag, 0);
    chk("R12", "ovr_flag", ovr_flag, 0);
    chk("R12", "trig_sel_q", int'(trig_sel_q), 0);

    // R1 / R4 / R11: every mask, two triggers each, whole list per trigger
    for (int m = 0; m < (1 << NCH); m++) begin
      ch_mask = NCH'(m);
      clear_logs();
      pulse_set();
      step(40);
      pulse_set();
      step(40);
      check_seq((m == 0) ? "R11" : "R4", m, 2 * popcnt(m));
      chk("R8", "start_flag after set", start_flag, 1);
      pulse_clr();
      chk("R8", "start_flag after clr", start_flag, 0);
    end
    chk("R10", "no overrun when idle", ovr_flag, 0);
    chk("R2", "eos without eoc", stray_eos, 0);

    // R3: discontinuous, one channel per trigger, wrap after highest
    discont_en = 1'b1;
    for (int m = 1; m < (1 << NCH); m++) begin
      do_reset();
      ch_mask = NCH'(m);
      clear_logs();
      for (int t = 0; t <= 2 * popcnt(m); t++) begin
        pulse_set();
        step(15);
        chk("R3", $sformatf("mask %0d conversions after trigger %0d", m, t), soc_log.size(), t + 1);
      end
      check_seq("R3", m, 2 * popcnt(m) + 1);
    end
    discont_en = 1'b0;

    // R5: continuous restart until start flag cleared
    do_reset();
    cont_en = 1'b1;
    ch_mask = 4'b0101;
    clear_logs();
    pulse_set();
    for (int w = 0; w < 200 && soc_log.size() < 6; w++) step(1);
    pulse_clr();
    step(30);
    check_seq("R5", 5, 6);
    chk("R5", "busy after stop", busy, 0);
    cont_en = 1'b0;

    // R6: illegal mode pair
    do_reset();
    discont_en = 1'b1; cont_en = 1'b1;
    ch_mask = 4'b1111;
    step(1);
    chk("R6", "cfg_err set", cfg_err, 1);
    clear_logs();
    pulse_set();
    step(20);
    chk("R6", "start_flag blocked", start_flag, 0);
    chk("R6", "no conversion", soc_log.size(), 0);
    discont_en = 1'b0; cont_en = 1'b0;
    step(1);
    chk("R6", "cfg_err clear", cfg_err, 0);

    // R7 / R9: selection lock and hardware edges
    do_reset();
    ch_mask = 4'b0001;
    write_sel(1);
    chk("R7", "write while stopped", int'(trig_sel_q), 1);
    pulse_set();
    step(20);
    clear_logs();
    hw_trig[0] = 1'b1; step(3); hw_trig[0] = 1'b0;
    step(20);
    chk("R9", "unselected line", soc_log.size(), 0);
    hw_trig[1] = 1'b1; step(30);
    chk("R9", "selected edge, held level", soc_log.size(), 1);
    hw_trig[1] = 1'b0; step(10);
    write_sel(0);
    chk("R7", "write while armed ignored", int'(trig_sel_q), 1);
    pulse_clr();
    hw_trig[1] = 1'b1; step(3); hw_trig[1] = 1'b0;
    step(20);
    chk("R9", "edge while not armed", soc_log.size(), 1);
    write_sel(0);
    chk("R7", "write after stop", int'(trig_sel_q), 0);

    // R10: overrun
    do_reset();
    ch_mask = 4'b1111;
    clear_logs();
    pulse_set();
    step(3);
    chk("R10", "no overrun yet", ovr_flag, 0);
    pulse_set();
    step(40);
    chk("R10", "overrun set", ovr_flag, 1);
    check_seq("R10", 15, 4);
    pulse_set();
    step(40);
    chk("R10", "overrun sticky", ovr_flag, 1);
    pulse_clr();

    summary();
    $finish;
  end
endmodule